// File: doc/BRIEF.md
# Early-out iterative mantissa left shifter

This block left-shifts a floating-point mantissa by a requested amount. It is meant for two jobs in an adder: lining up the smaller operand before the add, and normalizing the sum after it. A full log-stage barrel shifter is costly. This block uses one result register instead. A four-way multiplexer feeds that register, choosing between a fresh operand and the held value shifted left by one of three fixed distances: small, middle and large. Each cycle a controller applies the largest distance that still fits in the shift left to do. It stops as soon as nothing remains, so the number of cycles depends on the shift amount.

Operands arrive on a valid/ready stream and results leave on a valid/ready stream. Back-pressure rules:
- An operand is taken only in a cycle where `in_valid` and `in_ready` are both high.
- `in_ready` is low while a shift is in progress.
- `in_ready` is also low while a finished result waits with `out_ready` low.
- `in_ready` may depend combinationally on `out_ready`. A new operand can therefore be taken in the same cycle as the result handshake.
- A finished result stays on `out_data` with `out_valid` high until it is taken.
- After the result is taken, `out_data` keeps that value until the next operand is accepted.

The default setup is a 24-bit mantissa with distances 1, 3 and 7. A 53-bit setup with distances 1, 4 and 12 finishes any shift from 0 to 52 within 8 cycles.

Top module: `mant_step_shifter`

## Requirements
- R1: After reset `out_valid` and `busy` are 0, `in_ready` is 1 and `out_data` is all zeros.
- R2: `in_ready` is 1 in these two cases, and 0 in all others:
  - the block is idle and holds no untaken result;
  - it holds a result and `out_ready` is 1.
  
  An operand offered while `in_ready` is 0 is not taken and does not change any result.
- R3: The result equals the operand shifted left by `in_amt`. It is truncated to the mantissa width: bits moved past the MSB are lost and the vacated LSBs are zero.
- R4: With `in_amt` equal to 0, `out_valid` is high in the cycle after acceptance and `out_data` equals the operand.
- R5: With `in_amt` at or above the mantissa width (24 by default), the result is all zeros and `out_valid` is high in the cycle after acceptance.
- R6: For a nonzero amount below the width, each cycle applies the largest distance that does not exceed the remaining shift. `out_valid` rises after exactly as many cycles as that greedy sequence has steps.
- R7: For the default setup (width 24, distances 1, 3, 7), any amount from 0 to 23 yields `out_valid` at most 5 cycles after acceptance.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: After the result handshake, `out_data` keeps the last result until the next operand is accepted.
- R10: `busy` is high exactly in the cycles in which a shift step is applied. `out_valid` is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_data | input | WIDTH | Mantissa to shift |
| in_amt | input | $clog2(WIDTH) | Requested left shift |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | WIDTH | Shifted mantissa |
| busy | output | 1 | A shift step is applied this cycle |

## Verification
A wrong remaining-shift count or a wrong choice of distance shows up at the ports in two ways. `out_valid` rises one or more cycles earlier or later than the greedy step count predicts. The held `out_data` also differs from the reference shift, visible in the first cycle the result is offered. A controller stuck in the wrong state shows up within a cycle as a mismatch in `in_ready`, `busy` or `out_valid`, because all three are compared against a reference model on every clock. A result that changes while it waits under back-pressure, or after its handshake, is caught on the next clock.

// File: rtl/mshift_pkg.sv
package mshift_pkg;

  // Source selector for the result register
  typedef enum logic [1:0] {
    SRC_LOAD  = 2'd0,
    SRC_SMALL = 2'd1,
    SRC_MID   = 2'd2,
    SRC_LARGE = 2'd3
  } src_sel_t;

  // Number of greedy steps needed for a shift of amt
  function automatic int greedy_steps(int amt, int s, int m, int l);
    int r;
    int n;
    r = amt;
    n = 0;
    while (r > 0) begin
      if (r >= l)      r = r - l;
      else if (r >= m) r = r - m;
      else             r = r - s;
      n = n + 1;
    end
    return n;
  endfunction

  // Worst case over every in-range amount
  function automatic int worst_steps(int w, int s, int m, int l);
    int best;
    best = 0;
    for (int a = 0; a < w; a++) begin
      if (greedy_steps(a, s, m, l) > best) best = greedy_steps(a, s, m, l);
    end
    return best;
  endfunction

endpackage

// File: rtl/mshift_step_pick.sv
module mshift_step_pick
  import mshift_pkg::*;
#(
  parameter int AMT_W  = 5,
  parameter int STEP_S = 1,
  parameter int STEP_M = 3,
  parameter int STEP_L = 7
) (
  input  logic [AMT_W-1:0] remain,
  output src_sel_t         sel,
  output logic [AMT_W-1:0] step
);

  localparam logic [AMT_W-1:0] S_V = AMT_W'(STEP_S);
  localparam logic [AMT_W-1:0] M_V = AMT_W'(STEP_M);
  localparam logic [AMT_W-1:0] L_V = AMT_W'(STEP_L);

  // Largest distance not exceeding what is left
  always_comb begin
    if (remain >= L_V) begin
      sel  = SRC_LARGE;
      step = L_V;
    end else if (remain >= M_V) begin
      sel  = SRC_MID;
      step = M_V;
    end else if (remain >= S_V) begin
      sel  = SRC_SMALL;
      step = S_V;
    end else begin
      sel  = SRC_LOAD;
      step = '0;
    end
  end

endmodule

// File: rtl/mshift_datapath.sv
module mshift_datapath
  import mshift_pkg::*;
#(
  parameter int WIDTH  = 24,
  parameter int STEP_S = 1,
  parameter int STEP_M = 3,
  parameter int STEP_L = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  src_sel_t         sel,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] q
);

  localparam int NSRC = 4;
  localparam int STEP_TAB [NSRC-1] = '{STEP_S, STEP_M, STEP_L};

  logic [WIDTH-1:0] cand [NSRC];

  assign cand[0] = load_val;

  // One fixed-distance shifted copy per step size
  for (genvar g = 0; g < NSRC - 1; g++) begin : g_cand
    assign cand[g+1] = q << STEP_TAB[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= cand[sel];
  end

endmodule

// File: rtl/mshift_ctrl.sv
module mshift_ctrl
  import mshift_pkg::*;
#(
  parameter int WIDTH = 24,
  parameter int AMT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [AMT_W-1:0] in_amt,
  input  logic             out_ready,
  input  src_sel_t         pick_sel,
  input  logic [AMT_W-1:0] pick_step,
  output logic             in_ready,
  output logic             out_valid,
  output logic             busy,
  output logic             reg_en,
  output src_sel_t         reg_sel,
  output logic             load_zero,
  output logic [AMT_W-1:0] remain
);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD} state_t;

  localparam logic [AMT_W:0] WIDTH_V = (AMT_W+1)'(WIDTH);

  state_t state_q, state_d;
  logic [AMT_W-1:0] remain_d;
  logic accept;
  logic amt_big;
  logic amt_zero;

  assign amt_big   = {1'b0, in_amt} >= WIDTH_V;
  assign amt_zero  = in_amt == '0;
  assign in_ready  = (state_q == ST_IDLE) || ((state_q == ST_HOLD) && out_ready);
  assign accept    = in_valid && in_ready;
  assign out_valid = state_q == ST_HOLD;
  assign busy      = state_q == ST_SHIFT;
  assign load_zero = amt_big;

  always_comb begin
    state_d  = state_q;
    remain_d = remain;
    reg_en   = 1'b0;
    reg_sel  = SRC_LOAD;
    if (accept) begin
      reg_en   = 1'b1;
      reg_sel  = SRC_LOAD;
      remain_d = in_amt;
      state_d  = (amt_zero || amt_big) ? ST_HOLD : ST_SHIFT;
    end else begin
      case (state_q)
        ST_SHIFT: begin
          reg_en   = 1'b1;
          reg_sel  = pick_sel;
          remain_d = remain - pick_step;
          if (remain == pick_step) state_d = ST_HOLD;
        end
        ST_HOLD: begin
          if (out_ready) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      remain  <= '0;
    end else begin
      state_q <= state_d;
      remain  <= remain_d;
    end
  end

endmodule

// File: rtl/mant_step_shifter.sv
module mant_step_shifter
  import mshift_pkg::*;
#(
  parameter int WIDTH  = 24,
  parameter int STEP_S = 1,
  parameter int STEP_M = 3,
  parameter int STEP_L = 7,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic [AMT_W-1:0] in_amt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             busy
);

  src_sel_t         pick_sel;
  src_sel_t         reg_sel;
  logic [AMT_W-1:0] pick_step;
  logic [AMT_W-1:0] remain;
  logic             reg_en;
  logic             load_zero;
  logic [WIDTH-1:0] load_val;

  assign load_val = load_zero ? '0 : in_data;

  mshift_step_pick #(
    .AMT_W (AMT_W),
    .STEP_S(STEP_S),
    .STEP_M(STEP_M),
    .STEP_L(STEP_L)
  ) u_pick (
    .remain(remain),
    .sel   (pick_sel),
    .step  (pick_step)
  );

  mshift_ctrl #(
    .WIDTH(WIDTH),
    .AMT_W(AMT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_amt   (in_amt),
    .out_ready(out_ready),
    .pick_sel (pick_sel),
    .pick_step(pick_step),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .busy     (busy),
    .reg_en   (reg_en),
    .reg_sel  (reg_sel),
    .load_zero(load_zero),
    .remain   (remain)
  );

  mshift_datapath #(
    .WIDTH (WIDTH),
    .STEP_S(STEP_S),
    .STEP_M(STEP_M),
    .STEP_L(STEP_L)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (reg_en),
    .sel     (reg_sel),
    .load_val(load_val),
    .q       (out_data)
  );

endmodule

// File: rtl/mant_step_shifter_chk.sv
module mant_step_shifter_chk
  import mshift_pkg::*;
#(
  parameter int WIDTH  = 24,
  parameter int STEP_S = 1,
  parameter int STEP_M = 3,
  parameter int STEP_L = 7,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_data,
  input logic [AMT_W-1:0] in_amt,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic             busy
);

  localparam int MAX_STEPS = worst_steps(WIDTH, STEP_S, STEP_M, STEP_L);

  logic             acc;
  int               busy_run;
  int               cap_amt;
  logic [WIDTH-1:0] low_mask;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= 0;
      cap_amt  <= 0;
    end else begin
      busy_run <= busy ? busy_run + 1 : 0;
      if (acc) cap_amt <= (int'(in_amt) >= WIDTH) ? WIDTH : int'(in_amt);
    end
  end

  always_comb begin
    low_mask = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (i < cap_amt) low_mask[i] = 1'b1;
    end
  end

  assert_no_take_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  assert_lsb_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & low_mask) == '0));

  assert_zero_amt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_amt == '0) |=> (out_valid && out_data == $past(in_data)));

  assert_big_amt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && int'(in_amt) >= WIDTH) |=> (out_valid && out_data == '0));

  assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < MAX_STEPS));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_idle_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !out_valid && !acc) |=> $stable(out_data));

  assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid);

endmodule

bind mant_step_shifter mant_step_shifter_chk #(
  .WIDTH (WIDTH),
  .STEP_S(STEP_S),
  .STEP_M(STEP_M),
  .STEP_L(STEP_L)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .in_amt   (in_amt),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .busy     (busy)
);

// File: tb/test_mant_step_shifter.sv
`timescale 1ns/1ps
module test_mant_step_shifter;

  localparam int W     = 24;
  localparam int AW    = 5;
  localparam int BOUND = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_data = '0;
  logic [AW-1:0] in_amt = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_data;
  logic          busy;

  always #10 clk = ~clk;

  mant_step_shifter i_mant_step_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_amt   (in_amt),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .busy     (busy)
  );

  int n_checks = 0;
  int n_fail = 0;

  // reference model state
  int           mcnt = 0;
  bit           mvalid = 0;
  logic [W-1:0] mdata = '0;
  bit           m_acc = 0;
  bit           prev_wait = 0;
  logic [W-1:0] prev_data = '0;
  bit           o_valid = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_steps(int amt);
    int r = amt;
    int n = 0;
    while (r > 0) begin
      if (r >= 7)      r -= 7;
      else if (r >= 3) r -= 3;
      else             r -= 1;
      n++;
    end
    return n;
  endfunction

  function automatic logic [W-1:0] ref_shift(logic [W-1:0] d, int amt);
    if (amt >= W) return '0;
    return d << amt;
  endfunction

  // One clock: compare outputs with the model, advance the model
  task automatic tick();
    bit exp_rdy;
    #1;
    o_valid = out_valid;
    exp_rdy = (mcnt == 0) && (!mvalid || out_ready);
    check(busy === (mcnt > 0), "R10 busy", W'(busy), W'(mcnt > 0));
    check(out_valid === mvalid, "R6 out_valid timing", W'(out_valid), W'(mvalid));
    check(in_ready === exp_rdy, "R2 in_ready", W'(in_ready), W'(exp_rdy));
    if (mcnt == 0)
      check(out_data === mdata, mvalid ? "R3 result" : "R9 held after handshake",
            out_data, mdata);
    if (prev_wait)
      check(out_data === prev_data, "R8 stable under back-pressure", out_data, prev_data);
    prev_wait = mvalid && !out_ready;
    prev_data = out_data;
    m_acc = in_valid && exp_rdy;
    if (m_acc) begin
      mdata  = ref_shift(in_data, int'(in_amt));
      mcnt   = (int'(in_amt) >= W) ? 0 : ref_steps(int'(in_amt));
      mvalid = (mcnt == 0);
    end else if (mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) mvalid = 1;
    end else if (mvalid && out_ready) begin
      mvalid = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // One transaction with optional back-pressure and ignored offers while busy
  task automatic xfer(input logic [W-1:0] d, input int amt, input int hold, input bit noise);
    int lat;
    in_valid  = 1'b1;
    in_data   = d;
    in_amt    = AW'(amt);
    out_ready = 1'b0;
    tick();
    while (!m_acc) tick();
    in_valid = noise;
    in_data  = ~d;
    in_amt   = '0;
    lat = 0;
    tick();
    while (!o_valid && lat < 40) begin
      lat++;
      tick();
    end
    if (amt == 0)
      check(lat == 0, "R4 zero amount latency", W'(lat), W'(0));
    else if (amt >= W)
      check(lat == 0 && out_data == '0, "R5 oversize amount", out_data, '0);
    else begin
      check(lat == ref_steps(amt), "R6 greedy step count", W'(lat), W'(ref_steps(amt)));
      check(lat <= BOUND, "R7 latency bound", W'(lat), W'(BOUND));
    end
    for (int i = 0; i < hold; i++) tick();
    in_valid  = 1'b0;
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
    tick();
  endtask

  function automatic logic [W-1:0] pattern(int k);
    case (k % 4)
      0: return 24'hFFFFFF;
      1: return 24'h800001;
      2: return 24'hA5C3E1;
      default: return W'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    int idx;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(out_valid === 1'b0, "R1 out_valid", W'(out_valid), '0);
    check(busy === 1'b0, "R1 busy", W'(busy), '0);
    check(in_ready === 1'b1, "R1 in_ready", W'(in_ready), W'(1));
    check(out_data === '0, "R1 out_data", out_data, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // every amount, several patterns, varying back-pressure
    for (int a = 0; a < 32; a++) begin
      xfer(pattern(a), a, a % 3, 1'b0);
      xfer(pattern(a + 1), a, 0, 1'b1);
    end

    // R2: offers during a shift and during a waiting result are ignored
    xfer(24'h123457, 23, 4, 1'b1);
    xfer(24'hFFFFFF, 19, 2, 1'b1);

    // back-to-back stream, consumer always ready
    idx = 0;
    out_ready = 1'b1;
    for (int c = 0; c < 200 && idx < 40; c++) begin
      in_valid = 1'b1;
      in_data  = pattern(idx) ^ W'(idx * 977);
      in_amt   = AW'((idx * 7) % 32);
      tick();
      if (m_acc) idx++;
    end
    in_valid = 1'b0;
    repeat (8) tick();
    out_ready = 1'b0;
    repeat (3) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule